// File: doc/BRIEF.md
# Software XON/XOFF Flow Controller

This block sits between a serial receiver and its receive FIFO, and next to the local transmitter. It watches each received byte and compares it against four programmable control characters: two resume characters and two suspend characters. A suspend match halts the local transmitter, and a resume match lets it run again. Matched control characters are removed from the received stream, so only ordinary data reaches the FIFO. In single mode one character is a complete control code. In double mode a control code is a pair of consecutive bytes: the first byte is compared with the first register of a kind and the next byte with the second.

The transmitter reads a registered hold signal. That signal changes only while the transmitter reports that no character is in flight, so a character already being shifted out always finishes. A sticky status flag records a suspend match, and an interrupt request follows it when enabled. Software clears the flag with an explicit strobe. Switching flow control off also clears the flag.

The receiver is assumed to deliver bytes with at least one idle cycle between strobes. The block uses that gap to emit a second byte when a held first character has to be released at the same moment as the byte that broke the sequence.

Top module: `swfc_top`

## Requirements
- R1: After reset all four character registers read as zero and `tx_hold`, `fifo_wr`, `xoff_flag` and `irq` are low. A byte equal to both a suspend and a resume character is treated as a suspend.
- R2: A write with `cfg_we` high loads `cfg_wdata` into the register chosen by `cfg_sel`: 0 = resume character 1, 1 = resume character 2, 2 = suspend character 1, 3 = suspend character 2.
- R3: In single mode with flow control on, a byte equal to suspend character 1 sets the halt request and `xoff_flag`. The byte is not written to the FIFO.
- R4: In single mode, a byte equal to resume character 1 clears the halt request and `xoff_flag`. The byte is dropped even when the transmitter was not suspended.
- R5: In double mode, suspend character 1 followed by suspend character 2 in the next received byte suspends, and the resume pair resumes. Neither byte of a matched pair reaches the FIFO.
- R6: In double mode, a held first character that is followed by a byte that does not complete its pair is written to the FIFO first. The new byte is then matched afresh: it either becomes the new held first character or is written one cycle later.
- R7: `tx_hold` follows the halt request one cycle later, and only while `tx_busy` is low. While `tx_busy` is high, `tx_hold` keeps its value.
- R8: `irq` is high exactly when `xoff_flag` is high and `irq_en` is high.
- R9: A `flag_clr` pulse clears `xoff_flag` and does not release `tx_hold`. A suspend match in the same cycle wins.
- R10: With `fc_en` low, every byte passes to the FIFO, the halt request and `xoff_flag` clear, and a held first character is released to the FIFO.
- R11: A non-control byte produces exactly one `fifo_wr` pulse carrying that byte, in the cycle after its strobe, and bytes keep their arrival order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Character register write strobe |
| cfg_sel | input | 2 | Character register select |
| cfg_wdata | input | 8 | Character register write data |
| fc_en | input | 1 | Flow control enable |
| dbl_mode | input | 1 | 1 = two-character control codes |
| irq_en | input | 1 | Interrupt enable |
| flag_clr | input | 1 | Clear strobe for the status flag |
| rx_valid | input | 1 | Received byte strobe |
| rx_data | input | 8 | Received byte |
| tx_busy | input | 1 | Transmitter is shifting a character |
| tx_hold | output | 1 | Transmitter must not start a new character |
| fifo_wr | output | 1 | Write strobe toward the receive FIFO |
| fifo_data | output | 8 | Byte written to the receive FIFO |
| xoff_flag | output | 1 | Sticky suspend-match status |
| irq | output | 1 | Interrupt request |

## Verification
The bench targets the moments where a held first character meets a byte that breaks its pair. This includes the case where the breaking byte itself starts a new resume pair. A design that dropped the held byte, emitted the two bytes in the wrong order, or lost the second write would leave the scoreboard short or out of order. The bench raises suspend matches while `tx_busy` is high; a design that changed `tx_hold` in the middle of a character shows the hold too early. The bench also checks that clearing the flag leaves the transmitter held, that a resume character arriving while running is still swallowed, and that zeroed registers after reset make a zero byte act as a suspend.

// File: rtl/swfc_pkg.sv
package swfc_pkg;
    localparam int unsigned NCHR  = 4;
    localparam int unsigned SEL_W = $clog2(NCHR);

    localparam int unsigned SEL_XON1  = 0;
    localparam int unsigned SEL_XON2  = 1;
    localparam int unsigned SEL_XOFF1 = 2;
    localparam int unsigned SEL_XOFF2 = 3;

    typedef struct packed {
        logic on1;
        logic on2;
        logic off1;
        logic off2;
    } hit_t;
endpackage

// File: rtl/swfc_chr_regs.sv
module swfc_chr_regs
    import swfc_pkg::*;
#(
    parameter int unsigned DW = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [SEL_W-1:0] sel,
    input  logic [DW-1:0]    wdata,
    output logic [DW-1:0]    xon1,
    output logic [DW-1:0]    xon2,
    output logic [DW-1:0]    xoff1,
    output logic [DW-1:0]    xoff2
);
    logic [DW-1:0] chr_d [NCHR];
    logic [DW-1:0] chr_q [NCHR];

    for (genvar i = 0; i < NCHR; i++) begin : g_chr
        always_comb begin
            chr_d[i] = chr_q[i];
            if (we && (sel == SEL_W'(i))) begin
                chr_d[i] = wdata;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                chr_q[i] <= '0;
            end else begin
                chr_q[i] <= chr_d[i];
            end
        end

        AST_REG_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
            !(we && (sel == SEL_W'(i))) |=> $stable(chr_q[i])); // R2
    end

    assign xon1  = chr_q[SEL_XON1];
    assign xon2  = chr_q[SEL_XON2];
    assign xoff1 = chr_q[SEL_XOFF1];
    assign xoff2 = chr_q[SEL_XOFF2];
endmodule

// File: rtl/swfc_match.sv
module swfc_match
    import swfc_pkg::*;
#(
    parameter int unsigned DW = 8
) (
    input  logic [DW-1:0] byte_in,
    input  logic [DW-1:0] xon1,
    input  logic [DW-1:0] xon2,
    input  logic [DW-1:0] xoff1,
    input  logic [DW-1:0] xoff2,
    output hit_t          hit
);
    always_comb begin
        hit.on1  = (byte_in == xon1);
        hit.on2  = (byte_in == xon2);
        hit.off1 = (byte_in == xoff1);
        hit.off2 = (byte_in == xoff2);
    end
endmodule

// File: rtl/swfc_txgate.sv
module swfc_txgate (
    input  logic clk,
    input  logic rst_n,
    input  logic halt_req,
    input  logic tx_busy,
    output logic tx_hold
);
    logic hold_d, hold_q;

    always_comb begin
        hold_d = hold_q;
        if (!tx_busy) begin
            hold_d = halt_req;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q <= 1'b0;
        end else begin
            hold_q <= hold_d;
        end
    end

    assign tx_hold = hold_q;

    AST_HOLD_FROZEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        tx_busy |=> $stable(hold_q)); // R7
    AST_HOLD_TRACKS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_busy |=> (hold_q == $past(halt_req))); // R7
endmodule

// File: rtl/swfc_ctrl.sv
module swfc_ctrl
    import swfc_pkg::*;
#(
    parameter int unsigned DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fc_en,
    input  logic          dbl_mode,
    input  logic          flag_clr,
    input  logic          rx_valid,
    input  logic [DW-1:0] rx_data,
    input  hit_t          hit,
    output logic          halt_req,
    output logic          flag,
    output logic          out_v,
    output logic [DW-1:0] out_data
);
    typedef struct packed {
        logic          pend;
        logic          p_on;
        logic          p_off;
        logic [DW-1:0] p_data;
        logic          halt;
        logic          flag;
        logic          out_v;
        logic [DW-1:0] out_data;
        logic          spill_v;
        logic [DW-1:0] spill_data;
    } st_t;

    st_t s_d, s_q;

    logic dbl, full_off, full_on, rel, pass_v;

    always_comb begin
        s_d       = s_q;
        s_d.out_v = 1'b0;

        dbl      = fc_en && dbl_mode;
        full_off = s_q.pend && s_q.p_off && hit.off2;
        full_on  = s_q.pend && s_q.p_on && hit.on2;
        rel      = s_q.pend && (!dbl || (rx_valid && !full_off && !full_on));
        pass_v   = 1'b0;

        // a byte left over from the previous cycle goes out first
        if (s_q.spill_v) begin
            s_d.out_v    = 1'b1;
            s_d.out_data = s_q.spill_data;
            s_d.spill_v  = 1'b0;
        end

        if (flag_clr) begin
            s_d.flag = 1'b0;
        end

        if (rel) begin
            s_d.pend = 1'b0;
        end

        if (rx_valid) begin
            if (!fc_en) begin
                pass_v = 1'b1;
            end else if (!dbl_mode) begin
                if (hit.off1) begin
                    s_d.halt = 1'b1;
                    s_d.flag = 1'b1;
                end else if (hit.on1) begin
                    s_d.halt = 1'b0;
                    s_d.flag = 1'b0;
                end else begin
                    pass_v = 1'b1;
                end
            end else begin
                if (full_off) begin
                    s_d.halt = 1'b1;
                    s_d.flag = 1'b1;
                    s_d.pend = 1'b0;
                end else if (full_on) begin
                    s_d.halt = 1'b0;
                    s_d.flag = 1'b0;
                    s_d.pend = 1'b0;
                end else if (hit.off1 || hit.on1) begin
                    s_d.pend   = 1'b1;
                    s_d.p_off  = hit.off1;
                    s_d.p_on   = hit.on1;
                    s_d.p_data = rx_data;
                end else begin
                    pass_v = 1'b1;
                end
            end
        end

        // held byte takes the earlier slot, the new byte the later one
        if (rel) begin
            if (!s_d.out_v) begin
                s_d.out_v    = 1'b1;
                s_d.out_data = s_q.p_data;
            end else begin
                s_d.spill_v    = 1'b1;
                s_d.spill_data = s_q.p_data;
            end
        end
        if (pass_v) begin
            if (!s_d.out_v) begin
                s_d.out_v    = 1'b1;
                s_d.out_data = rx_data;
            end else begin
                s_d.spill_v    = 1'b1;
                s_d.spill_data = rx_data;
            end
        end

        if (!fc_en) begin
            s_d.halt = 1'b0;
            s_d.flag = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign halt_req = s_q.halt;
    assign flag     = s_q.flag;
    assign out_v    = s_q.out_v;
    assign out_data = s_q.out_data;

    AST_XOFF_SUSPENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && fc_en && !dbl_mode && hit.off1) |=> (s_q.halt && s_q.flag)); // R3
    AST_XON_RESUMES: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && fc_en && !dbl_mode && hit.on1 && !hit.off1) |=> (!s_q.halt && !s_q.flag)); // R4
    AST_CTRL_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && fc_en && !dbl_mode && (hit.off1 || hit.on1) && !s_q.spill_v && !s_q.pend)
        |=> !s_q.out_v); // R3
    AST_DISABLE_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        !fc_en |=> (!s_q.halt && !s_q.flag && !s_q.pend)); // R10
    AST_SPILL_BEHIND_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.spill_v |-> s_q.out_v); // R6
    AST_PASS_NEXT_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !fc_en && !s_q.spill_v && !s_q.pend)
        |=> (s_q.out_v && (s_q.out_data == $past(rx_data)))); // R11
endmodule

// File: rtl/swfc_top.sv
module swfc_top
    import swfc_pkg::*;
#(
    parameter int unsigned DW = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [SEL_W-1:0] cfg_sel,
    input  logic [DW-1:0]    cfg_wdata,
    input  logic             fc_en,
    input  logic             dbl_mode,
    input  logic             irq_en,
    input  logic             flag_clr,
    input  logic             rx_valid,
    input  logic [DW-1:0]    rx_data,
    input  logic             tx_busy,
    output logic             tx_hold,
    output logic             fifo_wr,
    output logic [DW-1:0]    fifo_data,
    output logic             xoff_flag,
    output logic             irq
);
    logic [DW-1:0] xon1, xon2, xoff1, xoff2;
    hit_t          hit;
    logic          halt_req;

    swfc_chr_regs #(.DW(DW)) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .sel   (cfg_sel),
        .wdata (cfg_wdata),
        .xon1  (xon1),
        .xon2  (xon2),
        .xoff1 (xoff1),
        .xoff2 (xoff2)
    );

    swfc_match #(.DW(DW)) u_match (
        .byte_in (rx_data),
        .xon1    (xon1),
        .xon2    (xon2),
        .xoff1   (xoff1),
        .xoff2   (xoff2),
        .hit     (hit)
    );

    swfc_ctrl #(.DW(DW)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .fc_en    (fc_en),
        .dbl_mode (dbl_mode),
        .flag_clr (flag_clr),
        .rx_valid (rx_valid),
        .rx_data  (rx_data),
        .hit      (hit),
        .halt_req (halt_req),
        .flag     (xoff_flag),
        .out_v    (fifo_wr),
        .out_data (fifo_data)
    );

    swfc_txgate u_gate (
        .clk      (clk),
        .rst_n    (rst_n),
        .halt_req (halt_req),
        .tx_busy  (tx_busy),
        .tx_hold  (tx_hold)
    );

    assign irq = xoff_flag & irq_en;
endmodule

// File: tb/tb_swfc_top.sv
module tb_swfc_top;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [1:0] cfg_sel = '0;
    logic [7:0] cfg_wdata = '0;
    logic       fc_en = 1'b0;
    logic       dbl_mode = 1'b0;
    logic       irq_en = 1'b0;
    logic       flag_clr = 1'b0;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_data = '0;
    logic       tx_busy = 1'b0;
    logic       tx_hold, fifo_wr, xoff_flag, irq;
    logic [7:0] fifo_data;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    logic [7:0] exp_q [$];

    always #(CLK_PERIOD/2) clk = ~clk;

    swfc_top dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .fc_en(fc_en), .dbl_mode(dbl_mode), .irq_en(irq_en), .flag_clr(flag_clr),
        .rx_valid(rx_valid), .rx_data(rx_data), .tx_busy(tx_busy), .tx_hold(tx_hold),
        .fifo_wr(fifo_wr), .fifo_data(fifo_data), .xoff_flag(xoff_flag), .irq(irq)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic cfg(input logic [1:0] sel, input logic [7:0] val);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = val;
        tick(1);
        cfg_we = 1'b0;
    endtask

    // driver: pushes the byte to the scoreboard if it must reach the FIFO
    task automatic send(input logic [7:0] b, input bit passes);
        if (passes) exp_q.push_back(b);
        rx_valid = 1'b1; rx_data = b;
        tick(1);
        rx_valid = 1'b0;
        tick(2);
    endtask

    // monitor: compares every FIFO write against the scoreboard
    always @(negedge clk) begin
        if (rst_n && fifo_wr) begin
            checks++;
            if (exp_q.size() == 0) begin
                fails++;
                $display("FAIL R11: actual write %h expected none", fifo_data);
            end else begin
                logic [7:0] e;
                e = exp_q.pop_front();
                if (fifo_data !== e) begin
                    fails++;
                    $display("FAIL R6/R11: actual %h expected %h", fifo_data, e);
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        // R1 reset state
        check("R1 tx_hold", {7'd0, tx_hold}, 8'd0);
        check("R1 fifo_wr", {7'd0, fifo_wr}, 8'd0);
        check("R1 xoff_flag", {7'd0, xoff_flag}, 8'd0);
        check("R1 irq", {7'd0, irq}, 8'd0);

        // R1 zeroed registers: zero byte acts as suspend
        fc_en = 1'b1;
        send(8'h00, 0);
        check("R1 zero byte suspends", {7'd0, tx_hold}, 8'd1);

        // R2 program registers; R4 resume character releases
        cfg(2'd0, 8'h11);
        cfg(2'd1, 8'h12);
        cfg(2'd2, 8'h13);
        cfg(2'd3, 8'h14);
        send(8'h00, 1);
        send(8'h11, 0);
        tick(1);
        check("R2/R4 resume via XON1", {7'd0, tx_hold}, 8'd0);
        check("R4 flag cleared", {7'd0, xoff_flag}, 8'd0);

        // R11 ordinary data in order
        send(8'h41, 1);
        send(8'h42, 1);
        send(8'h12, 1);

        // R3 / R8 suspend with interrupt
        irq_en = 1'b1;
        send(8'h13, 0);
        check("R3 hold", {7'd0, tx_hold}, 8'd1);
        check("R3 flag", {7'd0, xoff_flag}, 8'd1);
        check("R8 irq enabled", {7'd0, irq}, 8'd1);
        irq_en = 1'b0;
        tick(1);
        check("R8 irq masked", {7'd0, irq}, 8'd0);
        // R9 clear keeps transmitter held
        flag_clr = 1'b1; tick(1); flag_clr = 1'b0; tick(1);
        check("R9 flag cleared", {7'd0, xoff_flag}, 8'd0);
        check("R9 still held", {7'd0, tx_hold}, 8'd1);
        send(8'h11, 0);
        check("R4 resumed", {7'd0, tx_hold}, 8'd0);
        send(8'h11, 0);
        check("R4 XON dropped while running", {7'd0, tx_hold}, 8'd0);

        // R7 boundary
        tx_busy = 1'b1;
        send(8'h13, 0);
        check("R7 hold waits for boundary", {7'd0, tx_hold}, 8'd0);
        check("R7 flag set early", {7'd0, xoff_flag}, 8'd1);
        tx_busy = 1'b0;
        tick(2);
        check("R7 hold after boundary", {7'd0, tx_hold}, 8'd1);
        send(8'h11, 0);
        check("R7 released", {7'd0, tx_hold}, 8'd0);

        // R5 double mode pairs
        dbl_mode = 1'b1;
        send(8'h13, 0);
        check("R5 half pair no hold", {7'd0, tx_hold}, 8'd0);
        send(8'h14, 0);
        tick(1);
        check("R5 pair suspends", {7'd0, tx_hold}, 8'd1);
        send(8'h11, 0);
        send(8'h12, 0);
        tick(1);
        check("R5 pair resumes", {7'd0, tx_hold}, 8'd0);

        // R6 broken pair releases held byte first
        send(8'h13, 0);
        exp_q.push_back(8'h13);
        send(8'h41, 1);
        // R6 breaking byte starts a new resume pair
        send(8'h13, 0);
        send(8'h14, 0);
        tick(1);
        check("R6 setup suspend", {7'd0, tx_hold}, 8'd1);
        send(8'h13, 0);
        exp_q.push_back(8'h13);
        send(8'h11, 0);
        send(8'h12, 0);
        tick(1);
        check("R6 new pair resumes", {7'd0, tx_hold}, 8'd0);

        // R10 disable releases held byte and suspension
        send(8'h13, 0);
        exp_q.push_back(8'h13);
        fc_en = 1'b0;
        tick(2);
        send(8'h13, 1);
        send(8'h11, 1);
        check("R10 no hold while off", {7'd0, tx_hold}, 8'd0);
        fc_en = 1'b1; dbl_mode = 1'b0;
        send(8'h13, 0);
        check("R10 setup suspend", {7'd0, tx_hold}, 8'd1);
        fc_en = 1'b0;
        tick(2);
        check("R10 disable releases", {7'd0, tx_hold}, 8'd0);
        check("R10 disable clears flag", {7'd0, xoff_flag}, 8'd0);

        tick(3);
        checks++;
        if (exp_q.size() != 0) begin
            fails++;
            $display("FAIL R11: actual %0d bytes missing expected 0", exp_q.size());
        end
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule